// File: doc/BRIEF.md
# Decoupled Load-Store Unit

This unit sits between an in-order CPU pipeline and a single-master AHB-style bus. The pipeline hands it one memory command: load or store, a byte address, an access size, a first register index and a count of consecutive registers. For stores the pipeline also hands over the data of every register involved, captured when the command is accepted. The pipeline then keeps issuing instructions while the unit works through the bus beats on its own.

Any access may sit at any byte alignment. The unit cuts each register's access into the fewest naturally aligned bus beats. It places store bytes on the little-endian byte lanes. For loads it gathers the returned lanes into a zero-extended register value. Each loaded register is written back through a one-cycle valid pulse carrying its index. A stall output holds back an issuing instruction only when the unit is busy and the instruction is a memory command, or when one of its register operands is the target of a load that has not finished.

Top module: `lsu_top`

## Requirements
- R1: After reset, req_ready is 1, htrans is IDLE (2'b00), wb_valid is 0 and stall is 0 while no issue operand is valid.
- R2: A command presented with req_valid while req_ready is 1 is accepted at that clock edge, and its first address phase (htrans NONSEQ 2'b10, haddr equal to req_addr) is visible in the next cycle. req_ready stays 0 until the command ends, and req_valid during that time raises stall.
- R3: An issuing instruction whose valid operand indices (iss_rs1, iss_rs2, iss_rd) miss every register of the load in flight, or any instruction issued while a store is in flight, sees stall at 0.
- R4: stall is 1 when a valid operand index names a register of the load in flight that has not been written back, including the cycle in which its wb_valid pulse is shown.
- R5: Each beat's address phase drives htrans NONSEQ, and address, size and direction hold while hready is low. htrans is IDLE during data phases. hwdata holds through a data phase until hready is high.
- R6: req_size codes are 0 = byte, 1 = halfword, 2 = word (3 is taken as word). Every beat has hsize 0, 1 or 2 and an haddr aligned to that size.
- R7: Each register's access is cut into the minimum number of aligned beats. Examples: a word at offset 1 takes 3 beats, a word at offset 2 takes 2 beats, and a halfword at offset 3 takes 2 beats.
- R8: Byte order is little-endian. Byte n of a register goes to address base+n on byte lane (address mod 4). A load returns the bytes from the same places, zero-extended to 32 bits.
- R9: req_cnt holds the register count minus one. Registers move in ascending index order (modulo the register count) at addresses that rise by the access size per register.
- R10: A loaded register appears as a one-cycle wb_valid pulse with wb_idx and wb_data. The pulse comes in the cycle after the data phase of that register's last beat completes. For an aligned byte load with hready held high, it comes three cycles after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Memory command present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code per register |
| req_addr | input | ADDR_W | Byte address of first register's data |
| req_reg | input | IDX_W | First register index |
| req_cnt | input | CNT_W | Number of registers minus one |
| req_wdata | input | 32*MAX_MULT | Store data, register k in bits 32k+31..32k |
| req_ready | output | 1 | Unit idle, command can be accepted |
| iss_rs1_v | input | 1 | First source operand valid |
| iss_rs1 | input | IDX_W | First source register |
| iss_rs2_v | input | 1 | Second source operand valid |
| iss_rs2 | input | IDX_W | Second source register |
| iss_rd_v | input | 1 | Destination operand valid |
| iss_rd | input | IDX_W | Destination register |
| stall | output | 1 | Hold the issuing instruction |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | Bus write |
| hsize | output | 3 | Beat size |
| hwdata | output | 32 | Bus write data |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Bus ready |
| wb_valid | output | 1 | Write-back pulse |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
On every cycle the checker watches the bus rules: the legal transfer types, beats held while hready is low, data held through a waited data phase, and alignment of each beat. It also checks the stall behaviour against a busy unit and against the pending-load registers, the quiet bus while idle, and the single-cycle write-back pulse. The beat count for each alignment, the byte-lane placement, the zero extension, the register order and wrap of multi-register commands, and the exact cycle of the write-back can only be shown by the bench's scenarios. The bench runs these against its own memory model, with and without wait states.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} lsu_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  // number of bytes per register for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/lsu_beat_split.sv
// Picks the largest naturally aligned beat that fits the remaining bytes.
module lsu_beat_split (
  input  logic [1:0] a_lo,
  input  logic [2:0] rem,
  output logic [2:0] beat_bytes,
  output logic [1:0] beat_code
);
  always_comb begin
    if (a_lo == 2'd0 && rem >= 3'd4) begin
      beat_bytes = 3'd4;
      beat_code  = 2'd2;
    end else if (!a_lo[0] && rem >= 3'd2) begin
      beat_bytes = 3'd2;
      beat_code  = 2'd1;
    end else begin
      beat_bytes = 3'd1;
      beat_code  = 2'd0;
    end
  end
endmodule

// File: rtl/lsu_lane.sv
// Maps register bytes to bus lanes for one beat, both directions.
module lsu_lane (
  input  logic [1:0]  a_lo,
  input  logic [2:0]  beat_bytes,
  input  logic [1:0]  k_ofs,
  input  logic [31:0] elem_data,
  input  logic [31:0] rdata,
  input  logic [31:0] acc_in,
  output logic [31:0] wdata,
  output logic [31:0] acc_out
);
  always_comb begin
    wdata   = '0;
    acc_out = acc_in;
    for (int j = 0; j < 4; j++) begin
      logic [2:0] jj;
      logic [1:0] src;
      logic       in_beat;
      jj      = 3'(j);
      in_beat = (jj >= {1'b0, a_lo}) && (jj < ({1'b0, a_lo} + beat_bytes));
      src     = 2'(k_ofs + jj[1:0] - a_lo);
      if (in_beat) begin
        wdata[j*8 +: 8]            = elem_data[int'(src)*8 +: 8];
        acc_out[int'(src)*8 +: 8]  = rdata[j*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/lsu_hazard.sv
// Stall decision: busy unit versus memory command, or operand on a pending load.
module lsu_hazard #(
  parameter int NREG  = 16,
  parameter int IDX_W = 4
) (
  input  logic [NREG-1:0]  pend,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic             busy,
  input  logic             req_valid,
  input  logic             rs1_v,
  input  logic [IDX_W-1:0] rs1,
  input  logic             rs2_v,
  input  logic [IDX_W-1:0] rs2,
  input  logic             rd_v,
  input  logic [IDX_W-1:0] rd,
  output logic             stall
);
  logic [NREG-1:0] guard;

  always_comb begin
    guard = pend;
    if (wb_valid) guard[wb_idx] = 1'b1;
    stall = (req_valid && busy) ||
            (rs1_v && guard[rs1]) ||
            (rs2_v && guard[rs2]) ||
            (rd_v  && guard[rd]);
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top import lsu_pkg::*; #(
  parameter int NREG     = 16,
  parameter int MAX_MULT = 4,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = $clog2(NREG),
  localparam int CNT_W   = $clog2(MAX_MULT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_store,
  input  logic [1:0]              req_size,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [IDX_W-1:0]        req_reg,
  input  logic [CNT_W-1:0]        req_cnt,
  input  logic [32*MAX_MULT-1:0]  req_wdata,
  output logic                    req_ready,
  input  logic                    iss_rs1_v,
  input  logic [IDX_W-1:0]        iss_rs1,
  input  logic                    iss_rs2_v,
  input  logic [IDX_W-1:0]        iss_rs2,
  input  logic                    iss_rd_v,
  input  logic [IDX_W-1:0]        iss_rd,
  output logic                    stall,
  output logic [ADDR_W-1:0]       haddr,
  output logic [1:0]              htrans,
  output logic                    hwrite,
  output logic [2:0]              hsize,
  output logic [31:0]             hwdata,
  input  logic [31:0]             hrdata,
  input  logic                    hready,
  output logic                    wb_valid,
  output logic [IDX_W-1:0]        wb_idx,
  output logic [31:0]             wb_data
);
  localparam int SNAP_W = 32 * MAX_MULT;

  lsu_state_e            st_q;
  logic                  is_st_q;
  logic [2:0]            esz_q;
  logic [ADDR_W-1:0]     cur_q;
  logic [2:0]            k_q;
  logic [CNT_W-1:0]      elem_q;
  logic [CNT_W-1:0]      last_q;
  logic [IDX_W-1:0]      base_q;
  logic [31:0]           acc_q;
  logic [SNAP_W-1:0]     snap_q;
  logic [2:0]            beat_q;
  logic [NREG-1:0]       pend_q;

  logic [2:0]            rq_beat, nx_beat;
  logic [1:0]            rq_code, nx_code;
  logic [31:0]           elem_data, lane_wdata, lane_acc;
  logic [2:0]            nk, rem_n;
  logic [ADDR_W-1:0]     ncur;
  logic                  elem_done;
  logic [IDX_W-1:0]      cur_reg;
  logic [NREG-1:0]       new_mask;

  assign req_ready = (st_q == ST_IDLE);
  assign elem_data = snap_q[int'(elem_q)*32 +: 32];
  assign nk        = k_q + beat_q;
  assign ncur      = cur_q + ADDR_W'(beat_q);
  assign elem_done = (nk == esz_q);
  assign rem_n     = elem_done ? esz_q : (esz_q - nk);
  assign cur_reg   = base_q + IDX_W'(elem_q);

  always_comb begin
    new_mask = '0;
    for (int i = 0; i < MAX_MULT; i++)
      if (CNT_W'(i) <= req_cnt) new_mask[IDX_W'(req_reg + IDX_W'(i))] = 1'b1;
  end

  lsu_beat_split u_split_req (
    .a_lo(req_addr[1:0]), .rem(size_bytes(req_size)),
    .beat_bytes(rq_beat), .beat_code(rq_code)
  );

  lsu_beat_split u_split_nxt (
    .a_lo(ncur[1:0]), .rem(rem_n),
    .beat_bytes(nx_beat), .beat_code(nx_code)
  );

  lsu_lane u_lane (
    .a_lo(cur_q[1:0]), .beat_bytes(beat_q), .k_ofs(k_q[1:0]),
    .elem_data(elem_data), .rdata(hrdata), .acc_in(acc_q),
    .wdata(lane_wdata), .acc_out(lane_acc)
  );

  lsu_hazard #(.NREG(NREG), .IDX_W(IDX_W)) u_hazard (
    .pend(pend_q), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .busy(!req_ready), .req_valid(req_valid),
    .rs1_v(iss_rs1_v), .rs1(iss_rs1), .rs2_v(iss_rs2_v), .rs2(iss_rs2),
    .rd_v(iss_rd_v), .rd(iss_rd), .stall(stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      is_st_q  <= 1'b0;
      esz_q    <= 3'd1;
      cur_q    <= '0;
      k_q      <= '0;
      elem_q   <= '0;
      last_q   <= '0;
      base_q   <= '0;
      acc_q    <= '0;
      snap_q   <= '0;
      beat_q   <= 3'd1;
      pend_q   <= '0;
      haddr    <= '0;
      htrans   <= TR_IDLE;
      hwrite   <= 1'b0;
      hsize    <= '0;
      hwdata   <= '0;
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          st_q    <= ST_ADDR;
          is_st_q <= req_store;
          esz_q   <= size_bytes(req_size);
          cur_q   <= req_addr;
          k_q     <= '0;
          elem_q  <= '0;
          last_q  <= req_cnt;
          base_q  <= req_reg;
          snap_q  <= req_wdata;
          acc_q   <= '0;
          beat_q  <= rq_beat;
          pend_q  <= req_store ? '0 : new_mask;
          htrans  <= TR_NONSEQ;
          haddr   <= req_addr;
          hsize   <= {1'b0, rq_code};
          hwrite  <= req_store;
        end
        ST_ADDR: if (hready) begin
          st_q   <= ST_DATA;
          htrans <= TR_IDLE;
          hwdata <= is_st_q ? lane_wdata : '0;
        end
        ST_DATA: if (hready) begin
          cur_q <= ncur;
          if (elem_done) begin
            acc_q <= '0;
            k_q   <= '0;
            if (!is_st_q) begin
              wb_valid        <= 1'b1;
              wb_idx          <= cur_reg;
              wb_data         <= lane_acc;
              pend_q[cur_reg] <= 1'b0;
            end
          end else begin
            acc_q <= lane_acc;
            k_q   <= nk;
          end
          if (elem_done && elem_q == last_q) begin
            st_q   <= ST_IDLE;
            hwrite <= 1'b0;
          end else begin
            if (elem_done) elem_q <= elem_q + 1'b1;
            st_q   <= ST_ADDR;
            beat_q <= nx_beat;
            htrans <= TR_NONSEQ;
            haddr  <= ncur;
            hsize  <= {1'b0, nx_code};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_top_chk.sv
module lsu_top_chk #(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              stall,
  input logic              iss_rs1_v,
  input logic [IDX_W-1:0]  iss_rs1,
  input logic              iss_rd_v,
  input logic [IDX_W-1:0]  iss_rd,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hsize,
  input logic [31:0]       hwdata,
  input logic              hready,
  input logic              wb_valid,
  input logic [NREG-1:0]   pend
);
  logic dphase;

  always_ff @(posedge clk) begin
    if (rst) dphase <= 1'b0;
    else if (htrans == 2'b10 && hready) dphase <= 1'b1;
    else if (dphase && hready) dphase <= 1'b0;
  end

  p_htrans_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b00) || (htrans == 2'b10));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10 && !hready) |=>
      (htrans == 2'b10 && $stable(haddr) && $stable(hsize) && $stable(hwrite)));

  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dphase && !hready) |=> $stable(hwdata));

  p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10) |->
      (hsize <= 3'd2) && (hsize != 3'd1 || !haddr[0]) &&
      (hsize != 3'd2 || haddr[1:0] == 2'b00));

  p_busy_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |-> stall);

  p_dep_stall_r4: assert property (@(posedge clk) disable iff (rst)
    ((iss_rs1_v && pend[iss_rs1]) || (iss_rd_v && pend[iss_rd])) |-> stall);

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (htrans == 2'b00));

  p_wb_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);
endmodule

bind lsu_top lsu_top_chk #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .stall(stall), .iss_rs1_v(iss_rs1_v), .iss_rs1(iss_rs1),
  .iss_rd_v(iss_rd_v), .iss_rd(iss_rd), .haddr(haddr), .htrans(htrans),
  .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
  .wb_valid(wb_valid), .pend(pend_q)
);

// File: tb/tb_lsu_top.sv
module tb_lsu_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic       st;
    logic [1:0] sz;
    logic [7:0] addr;
    logic [1:0] cnt;
    logic [3:0] rg;
    logic [5:0] beats;
  } vec_t;

  // store/load, size code, address, count-1, first register, expected beats
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 8'h10, 2'd0, 4'd0,  6'd1},
    '{1'b1, 2'd2, 8'h21, 2'd0, 4'd0,  6'd3},
    '{1'b1, 2'd1, 8'h33, 2'd0, 4'd0,  6'd2},
    '{1'b1, 2'd0, 8'h45, 2'd0, 4'd0,  6'd1},
    '{1'b1, 2'd1, 8'h52, 2'd0, 4'd0,  6'd1},
    '{1'b1, 2'd2, 8'h62, 2'd0, 4'd0,  6'd2},
    '{1'b0, 2'd2, 8'h21, 2'd0, 4'd3,  6'd3},
    '{1'b0, 2'd1, 8'h33, 2'd0, 4'd4,  6'd2},
    '{1'b0, 2'd0, 8'h45, 2'd0, 4'd5,  6'd1},
    '{1'b1, 2'd2, 8'h81, 2'd2, 4'd0,  6'd9},
    '{1'b0, 2'd2, 8'h81, 2'd2, 4'd6,  6'd9},
    '{1'b1, 2'd1, 8'h93, 2'd3, 4'd0,  6'd8},
    '{1'b0, 2'd1, 8'h93, 2'd3, 4'd14, 6'd8},
    '{1'b0, 2'd2, 8'h62, 2'd0, 4'd1,  6'd2},
    '{1'b0, 2'd2, 8'h00, 2'd0, 4'd2,  6'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_store = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0;
  logic [3:0] req_reg = 0;
  logic [1:0] req_cnt = 0;
  logic [127:0] req_wdata = 0;
  logic req_ready;
  logic iss_rs1_v = 0, iss_rs2_v = 0, iss_rd_v = 0;
  logic [3:0] iss_rs1 = 0, iss_rs2 = 0, iss_rd = 0;
  logic stall;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0] htrans;
  logic hwrite;
  logic [2:0] hsize;
  logic hready = 1'b1;
  logic wb_valid;
  logic [3:0] wb_idx;
  logic [31:0] wb_data;

  int checks = 0, errors = 0;
  bit done = 0;

  lsu_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_addr(req_addr), .req_reg(req_reg),
    .req_cnt(req_cnt), .req_wdata(req_wdata), .req_ready(req_ready),
    .iss_rs1_v(iss_rs1_v), .iss_rs1(iss_rs1), .iss_rs2_v(iss_rs2_v),
    .iss_rs2(iss_rs2), .iss_rd_v(iss_rd_v), .iss_rd(iss_rd), .stall(stall),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus slave model with byte memory
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [31:0] s_addr = 0;
  logic s_wr = 0, s_dp = 0;
  logic [2:0] s_size = 0;
  int beats = 0, misalign = 0;
  bit wait_en = 0, hold_low = 0;
  int cyc = 0;

  assign hrdata = {mem[{s_addr[7:2], 2'd3}], mem[{s_addr[7:2], 2'd2}],
                   mem[{s_addr[7:2], 2'd1}], mem[{s_addr[7:2], 2'd0}]};

  always @(posedge clk) begin
    if (rst) s_dp <= 1'b0;
    else begin
      if (s_dp && hready) begin
        if (s_wr)
          for (int j = 0; j < 4; j++)
            if (j >= int'(s_addr[1:0]) && j < int'(s_addr[1:0]) + (1 << s_size))
              mem[{s_addr[7:2], 2'(j)}] <= hwdata[j*8 +: 8];
        s_dp <= 1'b0;
      end
      if (htrans == 2'b10 && hready) begin
        s_addr <= haddr;
        s_wr   <= hwrite;
        s_size <= hsize;
        s_dp   <= 1'b1;
        beats  <= beats + 1;
        if (hsize > 3'd2 || (hsize == 3'd1 && haddr[0]) ||
            (hsize == 3'd2 && haddr[1:0] != 2'b00))
          misalign <= misalign + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc    <= cyc + 1;
    hready <= !hold_low && (!wait_en || (cyc % 3 != 1));
  end

  // write-back monitor
  logic [3:0]  wb_idx_log [64];
  logic [31:0] wb_dat_log [64];
  int nwb = 0;
  always @(negedge clk) begin
    if (wb_valid && nwb < 64) begin
      wb_idx_log[nwb] = wb_idx;
      wb_dat_log[nwb] = wb_data;
      nwb = nwb + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sdata(int i, int e);
    return 32'h9E3779B9 * 32'(i * 4 + e + 1);
  endfunction

  function automatic logic [31:0] exp_load(int a, int n);
    logic [31:0] r = '0;
    for (int b = 0; b < n; b++) r[b*8 +: 8] = shadow[(a + b) & 255];
    return r;
  endfunction

  task automatic do_cmd(input int i);
    vec_t v = VEC[i];
    int n = (v.sz == 2'd0) ? 1 : (v.sz == 2'd1) ? 2 : 4;
    int wb0, b0, mism;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wait_en = (i % 2) == 1;
    wb0 = nwb; b0 = beats;
    req_store = v.st; req_size = v.sz; req_addr = {24'h0, v.addr};
    req_reg = v.rg; req_cnt = v.cnt;
    for (int e = 0; e < 4; e++) req_wdata[e*32 +: 32] = sdata(i, e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(htrans == 2'b10 && haddr == {24'h0, v.addr}, $sformatf("R2 first address vec %0d", i),
        haddr, {24'h0, v.addr});
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(beats - b0 == int'(v.beats), $sformatf("R7 beat count vec %0d", i),
        32'(beats - b0), 32'(v.beats));
    if (v.st) begin
      for (int e = 0; e <= int'(v.cnt); e++)
        for (int b = 0; b < n; b++)
          shadow[(int'(v.addr) + e * n + b) & 255] = sdata(i, e)[b*8 +: 8];
      mism = 0;
      for (int a = 0; a < 256; a++) if (mem[a] != shadow[a]) mism++;
      chk(mism == 0, $sformatf("R8 R9 stored bytes vec %0d", i), 32'(mism), 0);
    end else begin
      chk(nwb - wb0 == int'(v.cnt) + 1, $sformatf("R9 write-back count vec %0d", i),
          32'(nwb - wb0), 32'(int'(v.cnt) + 1));
      for (int e = 0; e <= int'(v.cnt) && wb0 + e < nwb; e++) begin
        chk(wb_idx_log[wb0 + e] == 4'(int'(v.rg) + e),
            $sformatf("R9 register order vec %0d", i),
            32'(wb_idx_log[wb0 + e]), 32'(4'(int'(v.rg) + e)));
        chk(wb_dat_log[wb0 + e] == exp_load(int'(v.addr) + e * n, n),
            $sformatf("R8 load data vec %0d", i),
            wb_dat_log[wb0 + e], exp_load(int'(v.addr) + e * n, n));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit seen;
    logic [31:0] a0;
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'(a * 7 + 3);
      shadow[a] = 8'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
    chk(htrans == 2'b00, "R1 htrans after reset", 32'(htrans), 0);
    chk(wb_valid == 1'b0, "R1 wb_valid after reset", 32'(wb_valid), 0);
    chk(stall == 1'b0, "R1 stall after reset", 32'(stall), 0);

    for (int i = 0; i < NV; i++) do_cmd(i);

    // R10 write-back timing, aligned byte load, no wait states
    wait_en = 0; hold_low = 0;
    repeat (2) @(negedge clk);
    req_store = 0; req_size = 2'd0; req_addr = 32'h45; req_reg = 4'd9; req_cnt = 0;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk(wb_valid == 1'b0, "R10 no pulse cycle 1", 32'(wb_valid), 0);
    @(negedge clk);
    chk(wb_valid == 1'b0, "R10 no pulse cycle 2", 32'(wb_valid), 0);
    @(negedge clk);
    chk(wb_valid == 1'b1 && wb_idx == 4'd9, "R10 pulse cycle 3", 32'(wb_valid), 1);
    chk(wb_data == {24'h0, shadow[8'h45]}, "R10 R8 zero-extended byte", wb_data,
        {24'h0, shadow[8'h45]});
    @(negedge clk);
    chk(wb_valid == 1'b0, "R10 single-cycle pulse", 32'(wb_valid), 0);

    // R3 store in flight does not stall dependent registers
    hold_low = 1;
    repeat (2) @(negedge clk);
    req_store = 1; req_size = 2'd2; req_addr = 32'hF0; req_reg = 4'd3; req_cnt = 0;
    req_wdata = '0;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    iss_rd_v = 1; iss_rd = 4'd3;
    @(negedge clk);
    chk(stall == 1'b0, "R3 no stall during store", 32'(stall), 0);
    iss_rd_v = 0;
    hold_low = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int b = 0; b < 4; b++) shadow[8'hF0 + b] = 8'h00;

    // R4 / R3 / R2 / R5 with a multi-register load held by wait states
    hold_low = 1;
    repeat (2) @(negedge clk);
    req_store = 0; req_size = 2'd2; req_addr = 32'h81; req_reg = 4'd6; req_cnt = 2'd2;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    a0 = haddr;
    iss_rs1_v = 1; iss_rs1 = 4'd7;
    @(negedge clk);
    chk(stall == 1'b1, "R4 stall on pending source", 32'(stall), 1);
    iss_rs1 = 4'd9;
    @(negedge clk);
    chk(stall == 1'b0, "R3 no stall on unrelated source", 32'(stall), 0);
    iss_rs1_v = 0; iss_rd_v = 1; iss_rd = 4'd8;
    @(negedge clk);
    chk(stall == 1'b1, "R4 stall on pending destination", 32'(stall), 1);
    iss_rd_v = 0; iss_rs2_v = 1; iss_rs2 = 4'd5;
    @(negedge clk);
    chk(stall == 1'b0, "R3 no stall on second source miss", 32'(stall), 0);
    iss_rs2_v = 0; req_valid = 1'b1;
    @(negedge clk);
    chk(stall == 1'b1 && req_ready == 1'b0, "R2 stall on memory command while busy",
        32'(stall), 1);
    req_valid = 1'b0;
    chk(htrans == 2'b10 && haddr == a0 && haddr == 32'h81, "R5 address held while not ready",
        haddr, 32'h81);
    iss_rs1_v = 1; iss_rs1 = 4'd6;
    hold_low = 0;
    seen = 0;
    @(negedge clk);
    while (!req_ready) begin
      if (wb_valid && wb_idx == 4'd6) begin
        seen = 1;
        chk(stall == 1'b1, "R4 stall during write-back cycle", 32'(stall), 1);
      end
      @(negedge clk);
    end
    if (wb_valid && wb_idx == 4'd6) seen = 1;
    @(negedge clk);
    chk(seen, "R4 write-back of register 6 observed", 32'(seen), 1);
    chk(stall == 1'b0, "R4 stall released after load", 32'(stall), 0);
    iss_rs1_v = 0;

    chk(misalign == 0, "R6 every beat aligned", 32'(misalign), 0);
    chk(htrans == 2'b00, "R5 bus idle at end", 32'(htrans), 0);
    finish_run();
  end
endmodule